// File: doc/BRIEF.md
# DRAM Device-Side Cycle Decoder

This block sits on the device side of an asynchronous 1M x 1 dynamic memory interface. On every system clock edge it samples the active-low row strobe, column strobe and write enable, the ten address lines and the single data input. From the order in which those strobes change it works out what kind of cycle a memory controller is running. It carries out that cycle on a small bit array, drives the read bit with an enable that stands for the tri-state output, and keeps its own counter for the refresh row.

It can serve two purposes. As a memory emulator it answers a controller under test. As a checker it reports a one-cycle event for every completed cycle, with the cycle type, the row, the column and a page flag. Two sticky flags catch misuse: an access made before start-up refreshes are complete, and a row strobe held low for too long. Only the low `MEM_ROW_BITS` of the row and the low `MEM_COL_BITS` of the column select a stored bit. The reported addresses keep their full width.

Top module: `dram_cycle_decoder`

## Requirements
- R1: When the sampled row strobe goes low with the column strobe high in the previous or current sample, the address is taken as the row. A later sampled column-strobe fall with write enable high takes the column and opens a read. From the next cycle `dout_oe`=1 and `dout` holds the stored bit. When the column strobe rises, a one-cycle `evt_valid` pulse follows with `evt_kind`=1 and the latched row and column.
- R2: If write enable is low in the sample where the column strobe falls, the cycle is an early write. `din` from that sample is stored, `dout_oe` stays 0, and the closing event has `evt_kind`=2.
- R3: If write enable falls while an open read still has the column strobe low, `din` from that sample is written to the open cell. `dout` keeps the value read before the write, and the closing event has `evt_kind`=3.
- R4: Each column access inside one row-strobe-low period uses the row latched at its start. `evt_page` is 0 for the first access of the period and 1 for every later one.
- R5: A row-strobe low period with no column-strobe fall ends, in the sample where the row strobe is high again, with an event `evt_kind`=4 carrying the latched row and `evt_col`=0. `dout_oe` stays 0.
- R6: If the column strobe is low in both the previous and the current sample when the row strobe falls, the cycle is a column-before-row refresh. No cell changes and the address inputs are ignored. An event with `evt_kind`=5, `evt_row` equal to the 9-bit refresh counter (zero-extended) and `evt_col`=0 follows, and the counter then advances by one.
- R7: A column-before-row refresh that starts while a column access is still open is a hidden refresh. It reports `evt_kind`=6 in the same way as R6, and `dout` and `dout_oe` hold the read result until the column strobe rises.
- R8: `dout_oe` is 0 from the cycle after a sampled column-strobe rise, and `dout` reads 0 whenever `dout_oe` is 0. After reset both are 0.
- R9: The refresh counter wraps from 511 to 0.
- R10: A column access opened before `INIT_REFS` refresh cycles (kinds 4, 5 or 6) have completed since reset sets the sticky flag `viol_init`. Once the count has been reached, accesses leave it clear.
- R11: `viol_ras_long` is set, and stays set, when the row strobe is sampled low for more than `RAS_MAX_CYC` consecutive clocks. Exactly `RAS_MAX_CYC` low samples leave it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, 0 when not enabled |
| dout_oe | output | 1 | Output enable; 0 stands for high impedance |
| evt_valid | output | 1 | One-cycle pulse for a completed cycle |
| evt_kind | output | 3 | 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 column-before-row refresh, 6 hidden refresh |
| evt_page | output | 1 | Access was not the first one of its row period |
| evt_row | output | AW | Latched row, or refresh counter value |
| evt_col | output | AW | Latched column, 0 for refresh events |
| viol_init | output | 1 | Sticky: access before start-up refreshes |
| viol_ras_long | output | 1 | Sticky: row strobe low too long |

## Verification
The bench checks the edge-order corner cases. In the first, write enable is already low at the column fall. A decoder that tested it one sample late would run a read and drive the output. In the second, write enable falls later, and a design that got it wrong would either lose the old read value or fail to store `din`. The hidden refresh and the plain column-before-row refresh test whether a strobe held low is told apart from one that is falling. A wrong decoder there latches a junk row, takes the address pins as the refresh row, drops the held read data, or reports an event twice. The counter wrap, the `INIT_REFS` limit taken one short and one exact, and a row-low period of exactly `RAS_MAX_CYC` against one clock longer catch off-by-one errors in the counters.

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int AW           = 10,
  parameter int REF_BITS     = 9,
  parameter int MEM_ROW_BITS = 4,
  parameter int MEM_COL_BITS = 4,
  parameter int INIT_REFS    = 8,
  parameter int RAS_MAX_CYC  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic          dout,
  output logic          dout_oe,
  output logic          evt_valid,
  output logic [2:0]    evt_kind,
  output logic          evt_page,
  output logic [AW-1:0] evt_row,
  output logic [AW-1:0] evt_col,
  output logic          viol_init,
  output logic          viol_ras_long
);
  localparam int MW    = MEM_ROW_BITS + MEM_COL_BITS;
  localparam int DEPTH = 1 << MW;
  localparam int IW    = $clog2(INIT_REFS + 1);
  localparam int LW    = $clog2(RAS_MAX_CYC + 1);
  localparam logic [IW-1:0] INIT_LIM = IW'(INIT_REFS);
  localparam logic [LW-1:0] LOW_LIM  = LW'(RAS_MAX_CYC);

  localparam logic [2:0] K_READ  = 3'd1;
  localparam logic [2:0] K_EWR   = 3'd2;
  localparam logic [2:0] K_RMW   = 3'd3;
  localparam logic [2:0] K_RONLY = 3'd4;
  localparam logic [2:0] K_CBR   = 3'd5;
  localparam logic [2:0] K_HID   = 3'd6;

  logic                p_ras, p_cas, p_we;
  logic [AW-1:0]       row_q, col_q;
  logic [REF_BITS-1:0] ref_cnt;
  logic                ref_q, seen_q;
  logic                acc_open, acc_page;
  logic [2:0]          acc_kind;
  logic [IW-1:0]       init_cnt;
  logic [LW-1:0]       low_cnt;
  logic [DEPTH-1:0]    mem_q;

  wire ras_fall = p_ras & ~ras_n;
  wire ras_rise = ~p_ras & ras_n;
  wire cas_fall = p_cas & ~cas_n;
  wire cas_rise = ~p_cas & cas_n;
  wire we_fall  = p_we & ~we_n;

  wire cbr_go   = ras_fall & ~p_cas & ~cas_n;
  wire row_go   = ras_fall & ~cbr_go;
  wire ronly_go = ras_rise & ~ref_q & ~seen_q;
  wire col_go   = cas_fall & ~ras_n & ~ref_q;
  wire rmw_go   = we_fall & acc_open & (acc_kind == K_READ) & ~cas_n & ~ras_n & ~ref_q;
  wire ref_hit  = cbr_go | ronly_go;

  wire [AW-1:0] row_now = row_go ? addr : row_q;
  wire [MW-1:0] col_idx = {row_now[MEM_ROW_BITS-1:0], addr[MEM_COL_BITS-1:0]};
  wire [MW-1:0] rmw_idx = {row_q[MEM_ROW_BITS-1:0], col_q[MEM_COL_BITS-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ras         <= 1'b1;
      p_cas         <= 1'b1;
      p_we          <= 1'b1;
      row_q         <= '0;
      col_q         <= '0;
      ref_cnt       <= '0;
      ref_q         <= 1'b0;
      seen_q        <= 1'b0;
      acc_open      <= 1'b0;
      acc_page      <= 1'b0;
      acc_kind      <= '0;
      init_cnt      <= '0;
      low_cnt       <= '0;
      mem_q         <= '0;
      dout          <= 1'b0;
      dout_oe       <= 1'b0;
      evt_valid     <= 1'b0;
      evt_kind      <= '0;
      evt_page      <= 1'b0;
      evt_row       <= '0;
      evt_col       <= '0;
      viol_init     <= 1'b0;
      viol_ras_long <= 1'b0;
    end else begin
      p_ras     <= ras_n;
      p_cas     <= cas_n;
      p_we      <= we_n;
      evt_valid <= 1'b0;

      if (ras_n)                   low_cnt <= '0;
      else if (low_cnt != LOW_LIM) low_cnt <= low_cnt + 1'b1;
      if (!ras_n && low_cnt == LOW_LIM) viol_ras_long <= 1'b1;

      if (ref_hit && init_cnt != INIT_LIM) init_cnt <= init_cnt + 1'b1;

      if (row_go) begin
        row_q  <= addr;
        seen_q <= 1'b0;
      end

      if (cbr_go) begin
        ref_q     <= 1'b1;
        ref_cnt   <= ref_cnt + 1'b1;
        evt_valid <= 1'b1;
        evt_kind  <= acc_open ? K_HID : K_CBR;
        evt_page  <= 1'b0;
        evt_row   <= AW'(ref_cnt);
        evt_col   <= '0;
      end

      if (ras_rise) ref_q <= 1'b0;

      if (ronly_go) begin
        evt_valid <= 1'b1;
        evt_kind  <= K_RONLY;
        evt_page  <= 1'b0;
        evt_row   <= row_q;
        evt_col   <= '0;
      end

      if (col_go) begin
        acc_open <= 1'b1;
        col_q    <= addr;
        seen_q   <= 1'b1;
        acc_page <= seen_q & ~row_go;
        if (init_cnt != INIT_LIM) viol_init <= 1'b1;
        if (!we_n) begin
          acc_kind       <= K_EWR;
          mem_q[col_idx] <= din;
          dout           <= 1'b0;
          dout_oe        <= 1'b0;
        end else begin
          acc_kind <= K_READ;
          dout     <= mem_q[col_idx];
          dout_oe  <= 1'b1;
        end
      end else if (cas_rise && acc_open) begin
        acc_open  <= 1'b0;
        dout      <= 1'b0;
        dout_oe   <= 1'b0;
        evt_valid <= 1'b1;
        evt_kind  <= acc_kind;
        evt_page  <= acc_page;
        evt_row   <= row_q;
        evt_col   <= col_q;
      end

      if (rmw_go) begin
        mem_q[rmw_idx] <= din;
        acc_kind       <= K_RMW;
      end
    end
  end
endmodule

// File: rtl/dram_cycle_decoder_chk.sv
module dram_cycle_decoder_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          dout,
  input logic          dout_oe,
  input logic          evt_valid,
  input logic [2:0]    evt_kind,
  input logic          viol_init,
  input logic          viol_ras_long
);
  p_evt_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_kind != 3'd0 && evt_kind != 3'd7));

  p_early_write_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |=> !dout_oe);

  p_ronly_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 3'd4) |-> !dout_oe);

  p_cbr_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n && !$past(cas_n)) |=> (evt_valid && (evt_kind == 3'd5 || evt_kind == 3'd6)));

  p_hidden_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 3'd6) |-> (dout_oe && $stable(dout)));

  p_cas_rise_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |=> !dout_oe);

  p_init_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_init |=> viol_init);

  p_ras_long_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    viol_ras_long |=> viol_ras_long);

  wire unused_ok = we_n;
endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .dout         (dout),
  .dout_oe      (dout_oe),
  .evt_valid    (evt_valid),
  .evt_kind     (evt_kind),
  .viol_init    (viol_init),
  .viol_ras_long(viol_ras_long)
);

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 10;
  localparam int RMAX = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic dout, dout_oe, evt_valid, evt_page, viol_init, viol_ras_long;
  logic [2:0] evt_kind;
  logic [AW-1:0] evt_row, evt_col;

  dram_cycle_decoder #(.AW(AW), .RAS_MAX_CYC(RMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_page(evt_page),
    .evt_row(evt_row), .evt_col(evt_col),
    .viol_init(viol_init), .viol_ras_long(viol_ras_long)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [2:0]    k;
    logic          pg;
    logic [AW-1:0] r;
    logic [AW-1:0] c;
  } ev_t;

  ev_t expq[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [255:0] mem_m = '0;
  int ref_m = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] k);
    case (k)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      ev_t e;
      if (expq.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R1 unexpected event: actual kind %0d expected none", evt_kind);
      end else begin
        e = expq.pop_front();
        chk(req_of(e.k), "event kind", 32'(evt_kind), 32'(e.k));
        chk(req_of(e.k), "event row", 32'(evt_row), 32'(e.r));
        chk(req_of(e.k), "event col", 32'(evt_col), 32'(e.c));
        chk("R4", "event page flag", 32'(evt_page), 32'(e.pg));
      end
    end
  end

  task automatic push(input logic [2:0] k, input logic pg, input logic [AW-1:0] r, input logic [AW-1:0] c);
    ev_t e;
    e.k = k; e.pg = pg; e.r = r; e.c = c;
    expq.push_back(e);
  endtask

  function automatic int mi(input logic [AW-1:0] r, input logic [AW-1:0] c);
    return int'({r[3:0], c[3:0]});
  endfunction

  task automatic cyc(input logic r, input logic c, input logic w, input logic [AW-1:0] a, input logic d);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; addr = '0; din = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mem_m = '0;
    ref_m = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] r, input logic [AW-1:0] c, input string req);
    push(3'd1, 1'b0, r, c);
    cyc(0, 1, 1, r, 0);
    cyc(0, 0, 1, c, 0);
    chk(req, "oe during read", 32'(dout_oe), 32'd1);
    chk(req, "read data", 32'(dout), 32'(mem_m[mi(r, c)]));
    cyc(1, 1, 1, '0, 0);
    chk("R8", "oe after CAS rise", 32'(dout_oe), 32'd0);
  endtask

  task automatic do_ewrite(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic d);
    push(3'd2, 1'b0, r, c);
    cyc(0, 1, 1, r, 0);
    cyc(0, 0, 0, c, d);
    chk("R2", "oe in early write", 32'(dout_oe), 32'd0);
    mem_m[mi(r, c)] = d;
    cyc(1, 1, 1, '0, 0);
  endtask

  task automatic do_rmw(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic d);
    logic old;
    old = mem_m[mi(r, c)];
    push(3'd3, 1'b0, r, c);
    cyc(0, 1, 1, r, 0);
    cyc(0, 0, 1, c, 0);
    chk("R3", "rmw read oe", 32'(dout_oe), 32'd1);
    chk("R3", "rmw read data", 32'(dout), 32'(old));
    cyc(0, 0, 0, c, d);
    chk("R3", "rmw oe after WE fall", 32'(dout_oe), 32'd1);
    chk("R3", "rmw keeps old data", 32'(dout), 32'(old));
    mem_m[mi(r, c)] = d;
    cyc(1, 1, 1, '0, 0);
  endtask

  task automatic do_ronly(input logic [AW-1:0] r);
    push(3'd4, 1'b0, r, '0);
    cyc(0, 1, 1, r, 0);
    cyc(0, 1, 1, r, 0);
    cyc(1, 1, 1, '0, 0);
    chk("R5", "oe after row-only refresh", 32'(dout_oe), 32'd0);
  endtask

  task automatic do_cbr(input logic [AW-1:0] junk);
    push(3'd5, 1'b0, AW'(ref_m), '0);
    ref_m = (ref_m + 1) % 512;
    cyc(1, 0, 1, junk, 1);
    cyc(0, 0, 1, junk, 1);
    cyc(0, 0, 0, junk, 1);
    cyc(1, 0, 1, junk, 1);
    cyc(1, 1, 1, '0, 0);
    chk("R6", "oe after refresh", 32'(dout_oe), 32'd0);
  endtask

  task automatic do_hidden(input logic [AW-1:0] r, input logic [AW-1:0] c);
    logic exp_d;
    exp_d = mem_m[mi(r, c)];
    push(3'd6, 1'b0, AW'(ref_m), '0);
    ref_m = (ref_m + 1) % 512;
    push(3'd1, 1'b0, r, c);
    cyc(0, 1, 1, r, 0);
    cyc(0, 0, 1, c, 0);
    chk("R7", "read data before hidden", 32'(dout), 32'(exp_d));
    cyc(1, 0, 1, 10'h155, 0);
    cyc(0, 0, 1, 10'h0AA, 0);
    chk("R7", "oe held in hidden", 32'(dout_oe), 32'd1);
    chk("R7", "data held in hidden", 32'(dout), 32'(exp_d));
    cyc(0, 0, 1, 10'h0AA, 0);
    cyc(1, 0, 1, 10'h0AA, 0);
    chk("R7", "data held after hidden", 32'(dout), 32'(exp_d));
    cyc(1, 1, 1, '0, 0);
    chk("R8", "oe after hidden CAS rise", 32'(dout_oe), 32'd0);
  endtask

  task automatic report();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R8", "reset oe", 32'(dout_oe), 32'd0);
    chk("R8", "reset dout", 32'(dout), 32'd0);
    chk("R1", "reset evt_valid", 32'(evt_valid), 32'd0);
    chk("R10", "reset viol_init", 32'(viol_init), 32'd0);
    chk("R11", "reset viol_ras_long", 32'(viol_ras_long), 32'd0);

    for (int i = 0; i < 7; i++) do_ronly(AW'(i));
    chk("R10", "no flag before access", 32'(viol_init), 32'd0);
    do_read(10'h005, 10'h003, "R1");
    chk("R10", "access after 7 refreshes", 32'(viol_init), 32'd1);
    repeat (3) cyc(1, 1, 1, '0, 0);

    do_reset();
    for (int i = 0; i < 8; i++) do_ronly(AW'(10'h100 + i));
    do_read(10'h005, 10'h003, "R1");
    chk("R10", "access after 8 refreshes", 32'(viol_init), 32'd0);

    do_ewrite(10'h2A3, 10'h015, 1'b1);
    do_read(10'h2A3, 10'h015, "R2");
    do_ewrite(10'h017, 10'h3F8, 1'b1);
    do_ewrite(10'h017, 10'h3F9, 1'b0);
    do_read(10'h017, 10'h3F8, "R2");

    do_rmw(10'h2A3, 10'h015, 1'b0);
    do_read(10'h2A3, 10'h015, "R3");
    do_rmw(10'h0C9, 10'h022, 1'b1);
    do_read(10'h0C9, 10'h022, "R3");

    // R4: page mode inside one row period
    push(3'd1, 1'b0, 10'h2A3, 10'h001);
    cyc(0, 1, 1, 10'h2A3, 0);
    cyc(0, 0, 1, 10'h001, 0);
    chk("R4", "page first read", 32'(dout), 32'(mem_m[mi(10'h2A3, 10'h001)]));
    cyc(0, 1, 1, 10'h3FF, 0);
    push(3'd2, 1'b1, 10'h2A3, 10'h00B);
    cyc(0, 0, 0, 10'h00B, 1);
    mem_m[mi(10'h2A3, 10'h00B)] = 1'b1;
    cyc(0, 1, 1, 10'h3FF, 0);
    push(3'd1, 1'b1, 10'h2A3, 10'h00B);
    cyc(0, 0, 1, 10'h00B, 0);
    chk("R4", "page read of page write", 32'(dout), 32'd1);
    chk("R4", "page read oe", 32'(dout_oe), 32'd1);
    cyc(0, 1, 1, 10'h3FF, 0);
    cyc(1, 1, 1, '0, 0);
    do_read(10'h0A3, 10'h02B, "R4");

    do_cbr(10'h3FF);
    do_cbr(10'h2A3);
    do_read(10'h2A3, 10'h015, "R6");
    do_read(10'h017, 10'h3F8, "R6");

    do_hidden(10'h017, 10'h3F8);
    do_hidden(10'h2A3, 10'h015);

    // R9: run the refresh counter past 511 back to 0
    while (ref_m != 0) do_cbr(10'h1C7);
    do_cbr(10'h1C7);
    do_cbr(10'h1C7);
    chk("R9", "model counter after wrap", 32'(ref_m), 32'd2);
    do_read(10'h0C9, 10'h022, "R9");

    // R11: row low for exactly the limit, then one more
    push(3'd4, 1'b0, 10'h033, '0);
    for (int i = 0; i < RMAX; i++) cyc(0, 1, 1, 10'h033, 0);
    chk("R11", "exact limit no flag", 32'(viol_ras_long), 32'd0);
    cyc(1, 1, 1, '0, 0);
    push(3'd4, 1'b0, 10'h034, '0);
    for (int i = 0; i < RMAX + 1; i++) cyc(0, 1, 1, 10'h034, 0);
    chk("R11", "limit plus one flag", 32'(viol_ras_long), 32'd1);
    cyc(1, 1, 1, '0, 0);
    cyc(1, 1, 1, '0, 0);
    chk("R11", "flag sticky", 32'(viol_ras_long), 32'd1);

    repeat (4) cyc(1, 1, 1, '0, 0);
    chk("R1", "events left unseen", 32'(expq.size()), 32'd0);
    report();
  end
endmodule